// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block holds the condition flags of a 32-bit integer core in a deferred form. An arithmetic unit does not compute X, N, Z, V and C for every instruction. It records a short operation tag together with the result word and the source operand. The flags are worked out only when a consumer asks for them with a flush. The flush folds the pending operation into an explicit flag vector and marks the state as settled, so a repeated flush costs nothing and changes nothing.

The block also contains the multi-precision add and subtract datapath. This datapath consumes the current extend flag as a carry or borrow, returns the arithmetic result, and writes settled flags directly. Its zero flag only accumulates across a chain of such operations: a nonzero word clears Z, and a zero word never sets it. A chained compare of a 64-bit or wider value therefore reports zero only when every word was zero.

Top module: `ccr_lazy_eval`

## Requirements
- R1: After reset, flags_o is 0, settled_o is 1, err_o is 0 and ext_res_o is 0. The flag vector is packed as {X,N,Z,V,C} in bits 4 down to 0.
- R2: A flush sets N to the top bit of the recorded result at the operation width, and sets Z when that result is zero.
- R3: For tag 3 (subtract, long), the minuend is result + source. C is set when the minuend is below the source, taken as unsigned. V is the top bit of (minuend XOR result) AND (minuend XOR source). X takes the value of C.
- R4: Tags 5, 6 and 7 (compare at byte, word and long) use the subtract rules on bits 7, 15 and 31. Bits above the width are ignored, and X keeps its previous value.
- R5: For tag 1 (add), C is set when the result is below the source, taken as unsigned. V is set when both addends share a sign and the result's sign differs. X takes the value of C.
- R6: For tag 2 (add with carry-in) and tag 4 (subtract with borrow-in), C is set when the result ≤ source (add) or the minuend ≤ source (subtract). Here the minuend is result + source + 1.
- R7: The datapath subtract, with ext_sub=1, returns ext_a − ext_b − X on ext_res_o one cycle later. C and X are set when ext_a ≤ ext_b if X was 1, and when ext_a < ext_b if X was 0.
- R8: The datapath add, with ext_sub=0, returns ext_a + ext_b + X. C and X are set when the result ≤ ext_b if X was 1, and when the result < ext_b if X was 0.
- R9: After a datapath operation, Z equals the previous settled Z AND (result == 0).
- R10: A flush leaves settled_o at 1. A flush while already settled leaves flags_o unchanged. A record clears settled_o.
- R11: Recording a tag in 8..15 pulses err_o for one cycle. The pending state and the flags stay as they were.
- R12: When several requests arrive in the same cycle, ext_go takes priority over rec_go, and rec_go takes priority over flush_go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_go | input | 1 | Record an operation tag and its operands |
| rec_code | input | 4 | Operation tag (0 settled, 1 add, 2 add+1, 3 sub, 4 sub−1, 5/6/7 compare byte/word/long) |
| rec_res | input | 32 | Result word of the recorded operation |
| rec_src | input | 32 | Source operand of the recorded operation |
| flush_go | input | 1 | Evaluate the pending tag into explicit flags |
| ext_go | input | 1 | Run an extended add or subtract |
| ext_sub | input | 1 | 1 selects subtract, 0 selects add |
| ext_a | input | 32 | First operand (minuend or addend) |
| ext_b | input | 32 | Second operand (subtrahend or addend) |
| flags_o | output | 5 | Flag register {X,N,Z,V,C} |
| settled_o | output | 1 | Flags are explicit, with no operation pending |
| ext_res_o | output | 32 | Result of the last extended operation |
| err_o | output | 1 | One-cycle pulse after an illegal tag is recorded |

## Verification
The hardest situation to reach is the sticky zero flag in both directions. It needs Z already cleared before a zero-result extended operation, and Z already set with X set before one. The bench reaches these states by recording and flushing chosen operations: a carry-in add that gives zero sets both X and Z, and a carry-out add sets X with Z clear. It then runs the datapath from each state. Byte and word compares are driven with junk in the upper bits, so that any leak from above the operation width shows up.

// File: rtl/ccr_lazy_eval.sv
module ccr_lazy_eval #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_go,
  input  logic [3:0]    rec_code,
  input  logic [DW-1:0] rec_res,
  input  logic [DW-1:0] rec_src,
  input  logic          flush_go,
  input  logic          ext_go,
  input  logic          ext_sub,
  input  logic [DW-1:0] ext_a,
  input  logic [DW-1:0] ext_b,
  output logic [4:0]    flags_o,
  output logic          settled_o,
  output logic [DW-1:0] ext_res_o,
  output logic          err_o
);
  localparam int MSB = DW - 1;
  localparam logic [3:0] T_DONE = 4'd0, T_ADD = 4'd1, T_ADDX = 4'd2, T_SUB = 4'd3,
                         T_SUBX = 4'd4, T_CMPB = 4'd5, T_CMPW = 4'd6, T_CMPL = 4'd7;

  logic [3:0]    tag_q;
  logic [DW-1:0] res_q, src_q;
  logic [4:0]    flags_q;
  logic [DW-1:0] xres_q;
  logic          err_q;

  function automatic logic [4:0] settle(input logic [3:0] t, input logic [DW-1:0] d,
                                        input logic [DW-1:0] s, input logic [4:0] f);
    logic [DW-1:0] ds, ss, a;
    logic n, z, v, c, x;
    int sh;
    sh = (t == T_CMPB) ? DW - 8 : (t == T_CMPW) ? DW - 16 : 0;
    ds = d << sh;
    ss = s << sh;
    n = ds[MSB];
    z = (ds == '0);
    x = f[4];
    v = 1'b0;
    c = 1'b0;
    a = '0;
    case (t)
      T_ADD, T_ADDX: begin
        a = (t == T_ADDX) ? ds - ss - 1'b1 : ds - ss;
        c = (t == T_ADDX) ? (ds <= ss) : (ds < ss);
        v = (a[MSB] == ss[MSB]) && (ds[MSB] != ss[MSB]);
        x = c;
      end
      T_SUB, T_SUBX, T_CMPB, T_CMPW, T_CMPL: begin
        a = (t == T_SUBX) ? ds + ss + 1'b1 : ds + ss;
        c = (t == T_SUBX) ? (a <= ss) : (a < ss);
        v = (a[MSB] ^ ds[MSB]) & (a[MSB] ^ ss[MSB]);
        if (t == T_SUB || t == T_SUBX) x = c;
      end
      default: ;
    endcase
    if (t == T_DONE || t > T_CMPL) settle = f;
    else settle = {x, n, z, v, c};
  endfunction

  logic [4:0]    cur;
  logic [3:0]    xtag;
  logic [DW-1:0] xsum;
  logic [4:0]    xflags;
  logic          rec_ok;

  assign cur    = settle(tag_q, res_q, src_q, flags_q);
  assign rec_ok = (rec_code <= T_CMPL);
  assign xsum   = ext_sub ? ext_a - ext_b - {{(DW-1){1'b0}}, cur[4]}
                          : ext_a + ext_b + {{(DW-1){1'b0}}, cur[4]};
  assign xtag   = ext_sub ? (cur[4] ? T_SUBX : T_SUB) : (cur[4] ? T_ADDX : T_ADD);

  always_comb begin
    xflags    = settle(xtag, xsum, ext_b, cur);
    xflags[2] = xflags[2] & cur[2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q   <= T_DONE;
      res_q   <= '0;
      src_q   <= '0;
      flags_q <= '0;
      xres_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (ext_go) begin
        flags_q <= xflags;
        xres_q  <= xsum;
        tag_q   <= T_DONE;
      end else if (rec_go) begin
        if (rec_ok) begin
          flags_q <= cur;
          tag_q   <= rec_code;
          res_q   <= rec_res;
          src_q   <= rec_src;
        end else begin
          err_q <= 1'b1;
        end
      end else if (flush_go) begin
        flags_q <= cur;
        tag_q   <= T_DONE;
      end
    end
  end

  assign flags_o   = flags_q;
  assign settled_o = (tag_q == T_DONE);
  assign ext_res_o = xres_q;
  assign err_o     = err_q;

  a_r10_flush_settles: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_go && !rec_go && !ext_go) |=> settled_o);
  a_r10_reflush_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_go && settled_o && !rec_go && !ext_go) |=> $stable(flags_o));
  a_r9_z_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ext_go |=> !(flags_o[2] && !$past(cur[2])));
  a_r11_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_go && !rec_ok && !ext_go) |=> (err_o && $stable(flags_o) && $stable(settled_o)));
  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(rec_go && !rec_ok && !ext_go));
  a_r12_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ext_go |=> settled_o);
endmodule

// File: tb/ccr_lazy_eval_test.sv
module ccr_lazy_eval_test;
  logic clk = 0, rst_n = 0;
  logic rec_go = 0, flush_go = 0, ext_go = 0, ext_sub = 0;
  logic [3:0] rec_code = 0;
  logic [31:0] rec_res = 0, rec_src = 0, ext_a = 0, ext_b = 0;
  logic [4:0] flags_o;
  logic settled_o, err_o;
  logic [31:0] ext_res_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ccr_lazy_eval uut (.clk(clk), .rst_n(rst_n), .rec_go(rec_go), .rec_code(rec_code),
    .rec_res(rec_res), .rec_src(rec_src), .flush_go(flush_go), .ext_go(ext_go),
    .ext_sub(ext_sub), .ext_a(ext_a), .ext_b(ext_b), .flags_o(flags_o),
    .settled_o(settled_o), .ext_res_o(ext_res_o), .err_o(err_o));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic rec(input logic [3:0] c, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk); rec_go = 1; rec_code = c; rec_res = d; rec_src = s;
    @(negedge clk); rec_go = 0;
  endtask

  task automatic flush();
    @(negedge clk); flush_go = 1;
    @(negedge clk); flush_go = 0;
  endtask

  task automatic ext(input logic sub, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk); ext_go = 1; ext_sub = sub; ext_a = a; ext_b = b;
    @(negedge clk); ext_go = 0;
  endtask

  task automatic t_reset();
    chk("R1 flags", flags_o, 0);
    chk("R1 settled", settled_o, 1);
    chk("R1 err", err_o, 0);
    chk("R1 res", ext_res_o, 0);
  endtask

  task automatic t_sub();
    rec(4'd3, 32'hFFFFFFFE, 32'd7); flush();
    chk("R3 R2 sub borrow", flags_o, 5'b11001);
    rec(4'd3, 32'h7FFFFFFF, 32'd1); flush();
    chk("R3 sub overflow", flags_o, 5'b00010);
    rec(4'd3, 32'd0, 32'd3); flush();
    chk("R2 sub zero", flags_o, 5'b00100);
  endtask

  task automatic t_cmp();
    rec(4'd3, 32'hFFFFFFFE, 32'd7); flush();
    rec(4'd5, 32'hFFFFFF7F, 32'h00000101); flush();
    chk("R4 byte compare", flags_o, 5'b10010);
    rec(4'd6, 32'h1234FFFF, 32'hAB000002); flush();
    chk("R4 word compare", flags_o, 5'b11001);
    rec(4'd6, 32'hFFFF0000, 32'd5); flush();
    chk("R4 R2 word zero", flags_o, 5'b10100);
    rec(4'd7, 32'd0, 32'd0); flush();
    chk("R4 long compare", flags_o, 5'b10100);
  endtask

  task automatic t_add();
    rec(4'd1, 32'h80000000, 32'd1); flush();
    chk("R5 add overflow", flags_o, 5'b01010);
    rec(4'd1, 32'd1, 32'd2); flush();
    chk("R5 add carry", flags_o, 5'b10001);
  endtask

  task automatic t_extrec();
    rec(4'd2, 32'd0, 32'd0); flush();
    chk("R6 addx equal", flags_o, 5'b10101);
    rec(4'd2, 32'd5, 32'd5); flush();
    chk("R6 addx carry", flags_o, 5'b10001);
    rec(4'd4, 32'hFFFFFFFF, 32'd4); flush();
    chk("R6 subx equal", flags_o, 5'b11001);
  endtask

  task automatic t_datapath();
    rec(4'd3, 32'd0, 32'd3); flush();
    ext(1'b0, 32'd5, 32'd6);
    chk("R8 add result", ext_res_o, 32'd11);
    chk("R8 add flags", flags_o, 5'b00000);
    rec(4'd1, 32'd1, 32'd2); flush();
    ext(1'b0, 32'hFFFFFFFF, 32'd0);
    chk("R8 add carry-in result", ext_res_o, 32'd0);
    chk("R8 R9 add carry-in flags", flags_o, 5'b10001);
    ext(1'b1, 32'd2, 32'd5);
    chk("R7 sub borrow-in result", ext_res_o, 32'hFFFFFFFC);
    chk("R7 sub borrow-in flags", flags_o, 5'b11001);
  endtask

  task automatic t_sticky();
    rec(4'd1, 32'd11, 32'd6); flush();
    ext(1'b1, 32'd7, 32'd7);
    chk("R9 zero stays clear res", ext_res_o, 32'd0);
    chk("R9 zero stays clear", flags_o, 5'b00000);
    rec(4'd2, 32'd0, 32'd0); flush();
    ext(1'b1, 32'd5, 32'd4);
    chk("R9 R7 zero kept", flags_o, 5'b00100);
    chk("R7 result", ext_res_o, 32'd0);
    ext(1'b0, 32'd3, 32'd4);
    chk("R9 zero cleared", flags_o, 5'b00000);
  endtask

  task automatic t_flush();
    rec(4'd3, 32'hFFFFFFFE, 32'd7);
    chk("R10 record pending", settled_o, 0);
    flush();
    chk("R10 settled", settled_o, 1);
    flush();
    chk("R10 second flush", flags_o, 5'b11001);
    chk("R10 still settled", settled_o, 1);
  endtask

  task automatic t_illegal();
    rec(4'd3, 32'd0, 32'd3);
    @(negedge clk); rec_go = 1; rec_code = 4'hB; rec_res = 32'h1; rec_src = 32'h1;
    @(negedge clk); rec_go = 0;
    chk("R11 err pulse", err_o, 1);
    chk("R11 still pending", settled_o, 0);
    @(negedge clk);
    chk("R11 err drops", err_o, 0);
    flush();
    chk("R11 pending kept", flags_o, 5'b00100);
  endtask

  task automatic t_prio();
    rec(4'd3, 32'h7FFFFFFF, 32'd1); flush();
    @(negedge clk); ext_go = 1; ext_sub = 0; ext_a = 32'd1; ext_b = 32'd1;
    rec_go = 1; rec_code = 4'd3; rec_res = 32'd0; rec_src = 32'd0; flush_go = 1;
    @(negedge clk); ext_go = 0; rec_go = 0; flush_go = 0;
    chk("R12 ext wins res", ext_res_o, 32'd2);
    chk("R12 ext wins settled", settled_o, 1);
    @(negedge clk); rec_go = 1; rec_code = 4'd3; rec_res = 32'd0; rec_src = 32'd0; flush_go = 1;
    @(negedge clk); rec_go = 0; flush_go = 0;
    chk("R12 record beats flush", settled_o, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_sub(); t_cmp(); t_add(); t_extrec(); t_datapath();
        t_sticky(); t_flush(); t_illegal(); t_prio();
      end
      begin
        repeat (200000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule